// File: doc/BRIEF.md
# Li-ion Charge Sequencer

This block is the digital sequencing core of a switching lithium-ion charger. It decides which charging phase the regulator is in: waiting, trickle charge of a deeply discharged cell, constant-current bulk charge, constant-voltage charge, top-off, or charge complete. Its inputs are comparator flags from the analog front end. Three describe the battery voltage: below the pre-charge level, at the termination level, and below the restart level. Two describe the charge current: below the end-of-charge level and below the top-off end level. It also takes an enable, a summary fault flag and a one-minute tick.

The block drives the phase code and a current-limit selector to the regulation loop. It contains two minute-based safety timers. Each timer has its own programmable code, its own disable value and its own window. When a timer expires, the block stops charging and emits a single-cycle strobe. Upstream status logic reports a bulk-timer expiry as a fault and a top-off expiry as a warning.

Top module: `chg_seq_top`

## Requirements
- R1: While `rst_n` is low, the state goes to IDLE (code 0), `ilim_sel` goes to 0 and both expiry strobes go low, all at the next clock edge.
- R2: When `en` is low or `fault_any` is high, the next state is IDLE from any state. The state stays IDLE for as long as either condition holds.
- R3: In IDLE with `en` high and `fault_any` low, the next state is PRE (code 1) if `vbat_lo` is high and CC (code 2) otherwise.
- R4: PRE moves to CC once `vbat_lo` is low. CC and CV (code 3) go back to PRE whenever `vbat_lo` is high.
- R5: CC moves to CV when `vbat_term` is high. CV moves to TOP (code 4) when `vbat_term` and `ichg_eoc` are both high.
- R6: TOP moves to DONE (code 5) when `vbat_term` and `ichg_topoff` are both high. DONE moves on when `vbat_rst` is high: to PRE if `vbat_lo` is high, otherwise to CC.
- R7: `ilim_sel` is 0 in IDLE and DONE, 1 in PRE, and 2 in CC, CV and TOP.
- R8: The bulk timer runs while the state is CC or CV. It counts `min_tick` cycles from its start. With `fc_code` = c in the range 1 to 7, the limit is 200·c ticks; `fc_code` = 0 disables the timer. The code is captured one cycle after the timer starts, and later changes to it have no effect.
- R9: When the bulk count reaches its limit, `fc_expire` pulses high for one cycle and the next state is IDLE. This expiry takes priority over every other transition out of CC or CV.
- R10: The top-off timer runs while the state is TOP. With `to_code` = c in the range 0 to 6, the limit is 20·c ticks; `to_code` = 7 disables it. On expiry, `to_expire` pulses for one cycle and the next state is DONE, unless R2 applies.
- R11: Each timer clears when its state set is left. A later entry counts from zero again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Charger enable |
| fault_any | input | 1 | Summary of all active faults |
| vbat_lo | input | 1 | Battery below the pre-charge level |
| vbat_term | input | 1 | Battery at the termination level |
| vbat_rst | input | 1 | Battery below the restart level |
| ichg_eoc | input | 1 | Charge current below the end-of-charge level |
| ichg_topoff | input | 1 | Charge current below the top-off end level |
| min_tick | input | 1 | One-cycle pulse once per minute |
| fc_code | input | 3 | Bulk timer code |
| to_code | input | 3 | Top-off timer code |
| state | output | 3 | Charge phase code |
| ilim_sel | output | 2 | Current-limit selector |
| fc_expire | output | 1 | Bulk timer expiry strobe |
| to_expire | output | 1 | Top-off timer expiry strobe |

## Verification
The bulk timer can expire in the same cycle that CV qualifies for top-off entry. To provoke this, the bench holds the state in CV with `ichg_eoc` low and waits for the `fc_expire` strobe. It then raises `ichg_eoc` inside that strobe cycle. The run passes only if the next state is IDLE and not TOP, so the expiry has won the priority.

// File: rtl/chg_seq_pkg.sv
// Package: shared state encoding and current-limit codes for the charge
// sequencer. Assumes a 3-bit state code visible at the top-level port.
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_CC   = 3'd2,
        ST_CV   = 3'd3,
        ST_TOP  = 3'd4,
        ST_DONE = 3'd5
    } chg_state_e;

    localparam logic [1:0] ILIM_OFF  = 2'd0;
    localparam logic [1:0] ILIM_PRE  = 2'd1;
    localparam logic [1:0] ILIM_FULL = 2'd2;

endpackage

// File: rtl/chg_seq_min_timer.sv
// Module: minute-based safety timer.
// Starts when run rises and captures the code one cycle later. It counts
// tick pulses until the count equals code*STEP and then raises expire for
// exactly one cycle. A code equal to DIS_CODE disables it. It clears
// whenever run is low. Assumes tick is a single-cycle pulse.
module chg_seq_min_timer #(
    parameter int CODE_W   = 3,
    parameter int STEP     = 200,
    parameter int DIS_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    input  logic              tick,
    output logic              expire
);
    localparam int MAX_LIM = STEP * ((1 << CODE_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    logic             active_q;
    logic             dis_q;
    logic             fired_q;
    logic             exp_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_w;

    // Limit derived from the programmed code.
    always_comb lim_w = CNT_W'(code) * CNT_W'(STEP);

    // Start capture, tick counting and one-shot expiry detection.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            active_q <= 1'b0;
            dis_q    <= 1'b0;
            fired_q  <= 1'b0;
            exp_q    <= 1'b0;
            lim_q    <= '0;
            cnt_q    <= '0;
        end else if (!active_q) begin
            active_q <= 1'b1;
            dis_q    <= (code == CODE_W'(DIS_CODE));
            lim_q    <= lim_w;
            cnt_q    <= '0;
            exp_q    <= 1'b0;
        end else begin
            exp_q <= 1'b0;
            if (!dis_q && !fired_q) begin
                if (cnt_q == lim_q) begin
                    exp_q   <= 1'b1;
                    fired_q <= 1'b1;
                end else if (tick) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Strobe only while the owning state is still current.
    always_comb expire = exp_q & run;

endmodule

// File: rtl/chg_seq_fsm.sv
// Module: charge phase state machine.
// The priority order is: disable or fault, then bulk-timer expiry, then
// top-off expiry, then the normal phase transitions. Assumes the
// comparator flags are already synchronous to clk.
module chg_seq_fsm
    import chg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       fault_any,
    input  logic       vbat_lo,
    input  logic       vbat_term,
    input  logic       vbat_rst,
    input  logic       ichg_eoc,
    input  logic       ichg_topoff,
    input  logic       fc_exp,
    input  logic       to_exp,
    output chg_state_e state_o,
    output logic [1:0] ilim_o,
    output logic       fc_run_o,
    output logic       to_run_o
);
    chg_state_e st_q;
    chg_state_e st_d;

    // Next-state selection with the priority order above.
    always_comb begin
        st_d = st_q;
        if (!en || fault_any) begin
            st_d = ST_IDLE;
        end else if (fc_exp) begin
            st_d = ST_IDLE;
        end else if (to_exp) begin
            st_d = ST_DONE;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = vbat_lo ? ST_PRE : ST_CC;
                ST_PRE:  if (!vbat_lo) st_d = ST_CC;
                ST_CC: begin
                    if (vbat_lo)        st_d = ST_PRE;
                    else if (vbat_term) st_d = ST_CV;
                end
                ST_CV: begin
                    if (vbat_lo)                    st_d = ST_PRE;
                    else if (vbat_term && ichg_eoc) st_d = ST_TOP;
                end
                ST_TOP:  if (vbat_term && ichg_topoff) st_d = ST_DONE;
                ST_DONE: if (vbat_rst) st_d = vbat_lo ? ST_PRE : ST_CC;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Current-limit code and timer run enables decoded from the state.
    always_comb begin
        unique case (st_q)
            ST_PRE:                ilim_o = ILIM_PRE;
            ST_CC, ST_CV, ST_TOP:  ilim_o = ILIM_FULL;
            default:               ilim_o = ILIM_OFF;
        endcase
        fc_run_o = (st_q == ST_CC) || (st_q == ST_CV);
        to_run_o = (st_q == ST_TOP);
    end

    assign state_o = st_q;

endmodule

// File: rtl/chg_seq_top.sv
// Module: charge sequencer top.
// Joins the phase state machine to the bulk and top-off safety timers.
// Assumes that min_tick is one cycle wide and that the fault summary is
// held high by upstream logic for as long as any fault is present.
module chg_seq_top
    import chg_seq_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int FC_STEP = 200,
    parameter int TO_STEP = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fault_any,
    input  logic              vbat_lo,
    input  logic              vbat_term,
    input  logic              vbat_rst,
    input  logic              ichg_eoc,
    input  logic              ichg_topoff,
    input  logic              min_tick,
    input  logic [CODE_W-1:0] fc_code,
    input  logic [CODE_W-1:0] to_code,
    output logic [2:0]        state,
    output logic [1:0]        ilim_sel,
    output logic              fc_expire,
    output logic              to_expire
);
    localparam int TO_DIS = (1 << CODE_W) - 1;

    chg_state_e st_w;
    logic       fc_run_w;
    logic       to_run_w;

    chg_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .fault_any   (fault_any),
        .vbat_lo     (vbat_lo),
        .vbat_term   (vbat_term),
        .vbat_rst    (vbat_rst),
        .ichg_eoc    (ichg_eoc),
        .ichg_topoff (ichg_topoff),
        .fc_exp      (fc_expire),
        .to_exp      (to_expire),
        .state_o     (st_w),
        .ilim_o      (ilim_sel),
        .fc_run_o    (fc_run_w),
        .to_run_o    (to_run_w)
    );

    chg_seq_min_timer #(.CODE_W(CODE_W), .STEP(FC_STEP), .DIS_CODE(0)) u_fc_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (fc_run_w),
        .code   (fc_code),
        .tick   (min_tick),
        .expire (fc_expire)
    );

    chg_seq_min_timer #(.CODE_W(CODE_W), .STEP(TO_STEP), .DIS_CODE(TO_DIS)) u_to_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (to_run_w),
        .code   (to_code),
        .tick   (min_tick),
        .expire (to_expire)
    );

    assign state = st_w;

endmodule

// File: rtl/chg_seq_chk.sv
// Module: temporal checker for the charge sequencer, bound to the top.
// It observes the top-level ports only.
module chg_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       fault_any,
    input logic       vbat_lo,
    input logic [2:0] state,
    input logic       fc_expire,
    input logic       to_expire
);
    // R2: disable or fault leads to IDLE.
    a_r2_off_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || fault_any) |=> (state == 3'd0));

    // R4: pre-charge leaves once the battery is above the pre-charge level.
    a_r4_pre_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'd1 && en && !fault_any && !vbat_lo) |=> (state == 3'd2));

    // R9: the bulk expiry strobe lasts one cycle and forces IDLE.
    a_r9_fc_single: assert property (@(posedge clk) disable iff (!rst_n)
        fc_expire |=> !fc_expire);
    a_r9_fc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fc_expire |=> (state == 3'd0));

    // R10: the top-off expiry strobe lasts one cycle and leads to DONE.
    a_r10_to_single: assert property (@(posedge clk) disable iff (!rst_n)
        to_expire |=> !to_expire);
    a_r10_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        (to_expire && en && !fault_any) |=> (state == 3'd5));

    // R8, R10: the strobes never overlap.
    a_r8_no_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(fc_expire && to_expire));

endmodule

bind chg_seq_top chg_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .fault_any (fault_any),
    .vbat_lo   (vbat_lo),
    .state     (state),
    .fc_expire (fc_expire),
    .to_expire (to_expire)
);

// File: tb/chg_seq_top_tb_top.sv
// Scoreboard bench for the charge sequencer. The driver pushes expected
// state and current-limit pairs; a negedge monitor pops and compares them.
module chg_seq_top_tb_top;

    localparam logic [2:0] S_IDLE = 3'd0, S_PRE = 3'd1, S_CC = 3'd2,
                           S_CV = 3'd3, S_TOP = 3'd4, S_DONE = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, fault_any = 1'b0, vbat_lo = 1'b0, vbat_term = 1'b0;
    logic       vbat_rst = 1'b0, ichg_eoc = 1'b0, ichg_topoff = 1'b0, min_tick = 1'b0;
    logic [2:0] fc_code = 3'd0, to_code = 3'd7;
    logic [2:0] state;
    logic [1:0] ilim_sel;
    logic       fc_expire, to_expire;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [2:0] st;
        logic [1:0] il;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    chg_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .fault_any(fault_any),
        .vbat_lo(vbat_lo), .vbat_term(vbat_term), .vbat_rst(vbat_rst),
        .ichg_eoc(ichg_eoc), .ichg_topoff(ichg_topoff), .min_tick(min_tick),
        .fc_code(fc_code), .to_code(to_code), .state(state),
        .ilim_sel(ilim_sel), .fc_expire(fc_expire), .to_expire(to_expire)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_st(input logic [2:0] st, input logic [1:0] il, input string tag);
        exp_item_t it;
        it.st = st; it.il = il; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compares the queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            chk(state == it.st, {it.tag, " state"}, state, it.st);
            chk(ilim_sel == it.il, {it.tag, " ilim"}, ilim_sel, it.il);
        end
    end

    int fc_cnt = 0;
    int to_cnt = 0;
    always @(negedge clk) begin
        if (fc_expire) fc_cnt++;
        if (to_expire) to_cnt++;
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        int base;
        // R1 reset state
        cyc(3);
        expect_st(S_IDLE, 2'd0, "R1");
        chk(!fc_expire && !to_expire, "R1 strobes", fc_expire + to_expire, 0);
        rst_n = 1'b1;
        cyc(2);
        expect_st(S_IDLE, 2'd0, "R2 en low");
        // R3 entry to pre-charge, R7 limit code
        en = 1'b1; vbat_lo = 1'b1;
        cyc(1); expect_st(S_PRE, 2'd1, "R3 to PRE / R7");
        cyc(3); expect_st(S_PRE, 2'd1, "R4 hold PRE");
        vbat_lo = 1'b0;
        cyc(1); expect_st(S_CC, 2'd2, "R4 PRE to CC / R7");
        vbat_lo = 1'b1;
        cyc(1); expect_st(S_PRE, 2'd1, "R4 CC to PRE");
        vbat_lo = 1'b0;
        cyc(1); expect_st(S_CC, 2'd2, "R4 back to CC");
        // R5 CC to CV to TOP
        vbat_term = 1'b1;
        cyc(1); expect_st(S_CV, 2'd2, "R5 CC to CV");
        cyc(2); expect_st(S_CV, 2'd2, "R5 hold CV");
        ichg_eoc = 1'b1;
        cyc(1); expect_st(S_TOP, 2'd2, "R5 CV to TOP / R7");
        // R6 top-off end and restart
        ichg_topoff = 1'b1;
        cyc(1); expect_st(S_DONE, 2'd0, "R6 TOP to DONE / R7");
        ichg_topoff = 1'b0; ichg_eoc = 1'b0;
        cyc(3); expect_st(S_DONE, 2'd0, "R6 hold DONE");
        vbat_term = 1'b0; vbat_rst = 1'b1;
        cyc(1); expect_st(S_CC, 2'd2, "R6 restart to CC");
        vbat_rst = 1'b0;
        // R2 fault and enable
        fault_any = 1'b1;
        cyc(1); expect_st(S_IDLE, 2'd0, "R2 fault");
        cyc(2); expect_st(S_IDLE, 2'd0, "R2 fault hold");
        fault_any = 1'b0;
        cyc(1); expect_st(S_CC, 2'd2, "R3 IDLE to CC");
        en = 1'b0;
        cyc(1); expect_st(S_IDLE, 2'd0, "R2 en low from CC");
        // R6 restart into PRE
        en = 1'b1; vbat_term = 1'b1; ichg_eoc = 1'b1;
        cyc(3); expect_st(S_TOP, 2'd2, "R6 reach TOP");
        ichg_topoff = 1'b1;
        cyc(1); expect_st(S_DONE, 2'd0, "R6 DONE");
        ichg_topoff = 1'b0; ichg_eoc = 1'b0; vbat_term = 1'b0;
        vbat_lo = 1'b1; vbat_rst = 1'b1;
        cyc(1); expect_st(S_PRE, 2'd1, "R6 restart to PRE");
        vbat_lo = 1'b0; vbat_rst = 1'b0;
        en = 1'b0;
        cyc(1);

        // R8 bulk timer, code 1 = 200 ticks
        fc_code = 3'd1; min_tick = 1'b1; en = 1'b1;
        cyc(1); expect_st(S_CC, 2'd2, "R8 start");
        cyc(200); expect_st(S_CC, 2'd2, "R8 before limit");
        chk(fc_cnt == 0, "R8 no early expiry", fc_cnt, 0);
        cyc(2);
        chk(fc_expire == 1'b1, "R9 strobe high", fc_expire, 1);
        cyc(1); expect_st(S_IDLE, 2'd0, "R9 to IDLE");
        chk(fc_expire == 1'b0, "R9 strobe single", fc_expire, 0);
        // R11 re-entry counts from zero; R8 code captured at start
        cyc(1); expect_st(S_CC, 2'd2, "R11 re-enter CC");
        cyc(2);
        fc_code = 3'd7;
        cyc(199); expect_st(S_CC, 2'd2, "R8 code change ignored");
        chk(fc_expire == 1'b0, "R8 not yet", fc_expire, 0);
        cyc(1);
        chk(fc_expire == 1'b1, "R8 captured code limit", fc_expire, 1);
        cyc(1); expect_st(S_IDLE, 2'd0, "R9 second expiry");
        en = 1'b0;
        cyc(1);
        // R11 leaving CC clears the count
        fc_code = 3'd1;
        base = fc_cnt;
        en = 1'b1;
        cyc(150);
        vbat_lo = 1'b1;
        cyc(2); expect_st(S_PRE, 2'd1, "R11 left to PRE");
        vbat_lo = 1'b0;
        cyc(150); expect_st(S_CC, 2'd2, "R11 no expiry after re-entry");
        chk(fc_cnt == base, "R11 count cleared", fc_cnt - base, 0);
        // R8 code 0 disables
        en = 1'b0; cyc(1);
        fc_code = 3'd0; en = 1'b1;
        cyc(1600); expect_st(S_CC, 2'd2, "R8 disabled code");
        chk(fc_cnt == base, "R8 disabled no strobe", fc_cnt - base, 0);
        // R9 priority: expiry collides with CV to TOP
        en = 1'b0; cyc(1);
        fc_code = 3'd1; en = 1'b1;
        cyc(1); vbat_term = 1'b1;
        cyc(1); expect_st(S_CV, 2'd2, "R9 in CV");
        for (int i = 0; i < 400 && !fc_expire; i++) cyc(1);
        chk(fc_expire == 1'b1, "R9 expiry seen in CV", fc_expire, 1);
        ichg_eoc = 1'b1;
        cyc(1); expect_st(S_IDLE, 2'd0, "R9 priority over TOP entry");
        en = 1'b0; ichg_eoc = 1'b0; vbat_term = 1'b0;
        cyc(1);

        // R10 top-off timer, code 1 = 20 ticks
        fc_code = 3'd0; to_code = 3'd1;
        en = 1'b1; vbat_term = 1'b1; ichg_eoc = 1'b1;
        cyc(3); expect_st(S_TOP, 2'd2, "R10 in TOP");
        cyc(21); expect_st(S_TOP, 2'd2, "R10 before limit");
        chk(to_expire == 1'b0, "R10 not yet", to_expire, 0);
        cyc(1);
        chk(to_expire == 1'b1, "R10 strobe", to_expire, 1);
        cyc(1); expect_st(S_DONE, 2'd0, "R10 to DONE");
        chk(to_expire == 1'b0, "R10 strobe single", to_expire, 0);
        // R10 code 0 expires right away
        to_code = 3'd0; vbat_rst = 1'b1;
        cyc(1); vbat_rst = 1'b0;
        cyc(2); expect_st(S_TOP, 2'd2, "R10 zero code TOP");
        cyc(2);
        chk(to_expire == 1'b1, "R10 zero code strobe", to_expire, 1);
        cyc(1); expect_st(S_DONE, 2'd0, "R10 zero code DONE");
        // R10 code 7 disables
        to_code = 3'd7; base = to_cnt; vbat_rst = 1'b1;
        cyc(1); vbat_rst = 1'b0;
        cyc(200); expect_st(S_TOP, 2'd2, "R10 disabled holds TOP");
        chk(to_cnt == base, "R10 disabled no strobe", to_cnt - base, 0);
        ichg_topoff = 1'b1;
        cyc(1); expect_st(S_DONE, 2'd0, "R6 end after disabled timer");
        min_tick = 1'b0;
        cyc(2);
        finish_up();
    end

endmodule